// File: doc/BRIEF.md
# Anode-Cathode Stub Time Coincidence Matcher

This block pairs trigger stubs from the two projections of a wire chamber. In every bunch crossing it can take up to two anode stubs (wire-group position and quality) and one cathode stub (half-strip position and quality). Cathode stubs are kept in a short shift register so that an anode stub can find a cathode partner from a few crossings before or after its own. The anode side goes through a matching delay line, so that cathode stubs from later crossings are also available when the match is made.

Each matched pair becomes one combined word. This word holds the summed quality, the anode wire group and the cathode half-strip. It is stamped with the crossing number that came in with the anode stub, because the anode timing is the more precise of the two. At most two matched words leave per crossing. A cathode stub is consumed by the first anode that takes it. The window width is chosen at run time as 1, 3 or 5 crossings, centred on the anode crossing.

Top module: `stub_coinc_matcher`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `out_vld` is 2'b00.
- R2: The result for anode stubs sampled at crossing t appears HMAX+1 clock edges later (3 with defaults). `out_bx` then equals the `bx_in` value sampled with those anode stubs.
- R3: Each output word is laid out as: bits [18:15] = anode quality + cathode quality, bits [14:8] = anode wire group, bits [7:0] = cathode half-strip.
- R4: A cathode stub can match only if its crossing lies within ±h of the anode crossing, where h = min(`win_sel`, HMAX). So `win_sel` 0 gives 1 crossing, 1 gives 3, and 2 or 3 give 5. Cathode stubs outside the window are ignored.
- R5: Among the free cathode stubs in the window, the one closest in time is chosen. When two are equally close, the one from the earlier crossing wins.
- R6: When both anode inputs are valid, the anode with the higher quality is paired first (anode 0 on equal quality). Its match, if any, goes to slot 0.
- R7: Output slots fill in order: `out_vld[1]` is never set unless `out_vld[0]` is set.
- R8: An anode stub with no free cathode stub in its window produces no output.
- R9: Each cathode stub is used in at most one match. It cannot be reused by the other anode of the same crossing or by an anode of a later crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| win_sel | input | 2 | Window half-width select (0..3) |
| bx_in | input | 12 | Crossing number sampled with the stubs |
| a_vld | input | 2 | Anode stub valid, one bit per anode input |
| a_wg | input | 2x7 | Anode wire-group positions |
| a_q | input | 2x3 | Anode qualities |
| c_vld | input | 1 | Cathode stub valid |
| c_hs | input | 8 | Cathode half-strip position |
| c_q | input | 3 | Cathode quality |
| out_vld | output | 2 | Matched word valid per slot |
| out_lct | output | 2x19 | Combined matched words |
| out_bx | output | 12 | Anode crossing of the matched words |

## Verification
Directed crossings place cathode stubs at chosen offsets from the anode: inside and just outside the window, two equally distant candidates, and a nearer candidate against a farther one. Each placement separates a correct window bound and closest-first order from off-by-one or later-first variants. Crossings with two anodes of unequal quality sharing one or two cathodes show whether pairing order and consumption are right. Random streams run at every window width and compare whole words and crossing stamps against a crossing-ordered model, which exposes errors in field packing and in consumption bookkeeping.

// File: rtl/smx_pkg.sv
package smx_pkg;
  // Search rank r -> window slot index; slot HMAX is the anode's own crossing,
  // larger index = earlier crossing. Odd ranks look earlier so ties go early.
  function automatic int rank_idx(input int r, input int hmax);
    if (r == 0) return hmax;
    else if (r % 2 == 1) return hmax + (r + 1) / 2;
    else return hmax - r / 2;
  endfunction

  function automatic int rank_dist(input int r);
    return (r + 1) / 2;
  endfunction
endpackage

// File: rtl/cath_window.sv
module cath_window #(
  parameter int HMAX  = 2,
  parameter int HS_W  = 8,
  parameter int CQ_W  = 3,
  parameter int DEPTH = 2 * HMAX + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      c_vld,
  input  logic [HS_W-1:0]           c_hs,
  input  logic [CQ_W-1:0]           c_q,
  input  logic [DEPTH-1:0]          consume,
  output logic [DEPTH-1:0]          w_vld,
  output logic [DEPTH-1:0][HS_W-1:0] w_hs,
  output logic [DEPTH-1:0][CQ_W-1:0] w_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      w_vld <= '0;
    end else begin
      w_vld[0] <= c_vld;
      for (int k = 1; k < DEPTH; k++) w_vld[k] <= w_vld[k-1] & ~consume[k-1];
    end
  end

  always_ff @(posedge clk) begin
    w_hs[0] <= c_hs;
    w_q[0]  <= c_q;
    for (int k = 1; k < DEPTH; k++) begin
      w_hs[k] <= w_hs[k-1];
      w_q[k]  <= w_q[k-1];
    end
  end
endmodule

// File: rtl/anode_delay.sv
module anode_delay #(
  parameter int STAGES = 3,
  parameter int V      = 2,
  parameter int W      = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [V-1:0] vin,
  input  logic [W-1:0] din,
  output logic [V-1:0] vout,
  output logic [W-1:0] dout
);
  logic [V-1:0] vp [STAGES];
  logic [W-1:0] dp [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) vp[k] <= '0;
    end else begin
      vp[0] <= vin;
      for (int k = 1; k < STAGES; k++) vp[k] <= vp[k-1];
    end
  end

  always_ff @(posedge clk) begin
    dp[0] <= din;
    for (int k = 1; k < STAGES; k++) dp[k] <= dp[k-1];
  end

  assign vout = vp[STAGES-1];
  assign dout = dp[STAGES-1];
endmodule

// File: rtl/stub_pick.sv
module stub_pick #(
  parameter int HMAX   = 2,
  parameter int WSEL_W = 2,
  parameter int DEPTH  = 2 * HMAX + 1,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              en,
  input  logic [DEPTH-1:0]  avail,
  input  logic [WSEL_W-1:0] half,
  output logic              found,
  output logic [IDX_W-1:0]  sel
);
  import smx_pkg::*;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int r = DEPTH - 1; r >= 0; r--) begin
      if (en && avail[rank_idx(r, HMAX)] && rank_dist(r) <= int'(half)) begin
        found = 1'b1;
        sel   = IDX_W'(rank_idx(r, HMAX));
      end
    end
  end
endmodule

// File: rtl/stub_coinc_matcher.sv
module stub_coinc_matcher #(
  parameter int HMAX   = 2,
  parameter int WG_W   = 7,
  parameter int HS_W   = 8,
  parameter int AQ_W   = 3,
  parameter int CQ_W   = 3,
  parameter int BX_W   = 12,
  parameter int WSEL_W = 2,
  parameter int QS_W   = ((AQ_W > CQ_W) ? AQ_W : CQ_W) + 1,
  parameter int LCT_W  = QS_W + WG_W + HS_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [WSEL_W-1:0]           win_sel,
  input  logic [BX_W-1:0]             bx_in,
  input  logic [1:0]                  a_vld,
  input  logic [1:0][WG_W-1:0]        a_wg,
  input  logic [1:0][AQ_W-1:0]        a_q,
  input  logic                        c_vld,
  input  logic [HS_W-1:0]             c_hs,
  input  logic [CQ_W-1:0]             c_q,
  output logic [1:0]                  out_vld,
  output logic [1:0][LCT_W-1:0]       out_lct,
  output logic [BX_W-1:0]             out_bx
);
  localparam int DEPTH = 2 * HMAX + 1;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int AW    = WG_W + AQ_W;
  localparam int D_W   = BX_W + 2 * AW;

  // cathode history
  logic [DEPTH-1:0]            w_vld, consume;
  logic [DEPTH-1:0][HS_W-1:0]  w_hs;
  logic [DEPTH-1:0][CQ_W-1:0]  w_q;

  cath_window #(.HMAX(HMAX), .HS_W(HS_W), .CQ_W(CQ_W)) cwin_i (
    .clk(clk), .rst(rst), .c_vld(c_vld), .c_hs(c_hs), .c_q(c_q),
    .consume(consume), .w_vld(w_vld), .w_hs(w_hs), .w_q(w_q));

  // anode path delayed so that future cathodes are in the window
  logic [1:0]     d_vld;
  logic [D_W-1:0] d_word;
  logic [BX_W-1:0] d_bx;
  logic [1:0][WG_W-1:0] d_wg;
  logic [1:0][AQ_W-1:0] d_q;

  anode_delay #(.STAGES(HMAX + 1), .V(2), .W(D_W)) adly_i (
    .clk(clk), .rst(rst), .vin(a_vld),
    .din({bx_in, a_wg[1], a_q[1], a_wg[0], a_q[0]}),
    .vout(d_vld), .dout(d_word));

  assign {d_bx, d_wg[1], d_q[1], d_wg[0], d_q[0]} = d_word;

  // window half-width, capped at HMAX
  logic [WSEL_W-1:0] half;
  assign half = (int'(win_sel) > HMAX) ? WSEL_W'(HMAX) : win_sel;

  // pairing order: higher-quality anode first, anode 0 on a tie
  logic pri;
  assign pri = d_vld[1] && (!d_vld[0] || (d_q[1] > d_q[0]));

  logic [1:0]            fnd;
  logic [1:0][IDX_W-1:0] sel;
  logic [1:0][DEPTH-1:0] avail;
  logic [1:0]            aidx;

  assign aidx[0] = pri;
  assign aidx[1] = ~pri;
  assign avail[0] = w_vld;
  assign avail[1] = w_vld & ~(fnd[0] ? (DEPTH'(1) << sel[0]) : '0);

  for (genvar p = 0; p < 2; p++) begin : g_pick
    stub_pick #(.HMAX(HMAX), .WSEL_W(WSEL_W)) pick_i (
      .en(d_vld[aidx[p]]), .avail(avail[p]), .half(half),
      .found(fnd[p]), .sel(sel[p]));
  end

  assign consume = (fnd[0] ? (DEPTH'(1) << sel[0]) : '0)
                 | (fnd[1] ? (DEPTH'(1) << sel[1]) : '0);

  // combined words
  logic [1:0][LCT_W-1:0] word;
  for (genvar p = 0; p < 2; p++) begin : g_word
    assign word[p] = {QS_W'(d_q[aidx[p]]) + QS_W'(w_q[sel[p]]),
                      d_wg[aidx[p]], w_hs[sel[p]]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 2'b00;
    end else if (fnd[0]) begin
      out_vld <= {fnd[1], 1'b1};
    end else begin
      out_vld <= {1'b0, fnd[1]};
    end
  end

  always_ff @(posedge clk) begin
    out_lct[0] <= fnd[0] ? word[0] : word[1];
    out_lct[1] <= word[1];
    out_bx     <= d_bx;
  end
endmodule

// File: rtl/smx_chk.sv
module smx_chk #(
  parameter int HMAX   = 2,
  parameter int BX_W   = 12,
  parameter int WSEL_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [WSEL_W-1:0] win_sel,
  input logic [BX_W-1:0]   bx_in,
  input logic [1:0]        a_vld,
  input logic              c_vld,
  input logic [1:0]        out_vld,
  input logic [BX_W-1:0]   out_bx
);
  localparam int P = HMAX + 2;
  logic [BX_W-1:0] bxp [P];
  logic [1:0]      ap  [P];
  logic            cp  [P];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < P; k++) begin
        bxp[k] <= '0; ap[k] <= '0; cp[k] <= 1'b0;
      end
    end else begin
      bxp[0] <= bx_in; ap[0] <= a_vld; cp[0] <= c_vld;
      for (int k = 1; k < P; k++) begin
        bxp[k] <= bxp[k-1]; ap[k] <= ap[k-1]; cp[k] <= cp[k-1];
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> out_vld == 2'b00);
  // R7
  slot_fill_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld[1] |-> out_vld[0]);
  // R2
  anode_bx_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld[0] |-> out_bx == bxp[HMAX+1]);
  // R8
  needs_anode_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld[0] |-> ap[HMAX+1] != 2'b00);
  // R8
  two_anodes_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld[1] |-> ap[HMAX+1] == 2'b11);
  // R4
  narrow_window_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld[0] && $past(win_sel) == '0) |-> cp[HMAX+1]);
  // R9
  single_use_chk: assert property (@(posedge clk) disable iff (rst)
    $past(win_sel) == '0 |-> !out_vld[1]);
endmodule

bind stub_coinc_matcher smx_chk #(.HMAX(HMAX), .BX_W(BX_W), .WSEL_W(WSEL_W)) chk_i (
  .clk(clk), .rst(rst), .win_sel(win_sel), .bx_in(bx_in), .a_vld(a_vld),
  .c_vld(c_vld), .out_vld(out_vld), .out_bx(out_bx));

// File: tb/stub_coinc_matcher_tb_top.sv
module stub_coinc_matcher_tb_top;
  localparam int HMAX = 2;
  localparam int NMAX = 600;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic [1:0] win_sel = '0;
  logic [11:0] bx_in = '0;
  logic [1:0] a_vld = '0;
  logic [1:0][6:0] a_wg = '0;
  logic [1:0][2:0] a_q = '0;
  logic c_vld = 1'b0;
  logic [7:0] c_hs = '0;
  logic [2:0] c_q = '0;
  logic [1:0] out_vld;
  logic [1:0][18:0] out_lct;
  logic [11:0] out_bx;

  stub_coinc_matcher dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  bit s_av [NMAX][2];
  int s_wg [NMAX][2];
  int s_aq [NMAX][2];
  bit s_cv [NMAX];
  int s_hs [NMAX];
  int s_cq [NMAX];
  logic [1:0]  e_vld [NMAX];
  logic [18:0] e_lct [NMAX][2];

  task automatic clear_stim();
    for (int t = 0; t < NMAX; t++) begin
      s_av[t][0] = 0; s_av[t][1] = 0; s_cv[t] = 0;
      s_wg[t][0] = 0; s_wg[t][1] = 0; s_aq[t][0] = 0; s_aq[t][1] = 0;
      s_hs[t] = 0; s_cq[t] = 0;
    end
  endtask

  task automatic put_a(int t, int k, int wg, int q);
    s_av[t][k] = 1; s_wg[t][k] = wg; s_aq[t][k] = q;
  endtask

  task automatic put_c(int t, int hs, int q);
    s_cv[t] = 1; s_hs[t] = hs; s_cq[t] = q;
  endtask

  // reference model, processed in crossing order
  task automatic model(int n, int win);
    bit used [NMAX];
    int h;
    h = (win > HMAX) ? HMAX : win;
    for (int t = 0; t < n; t++) used[t] = 0;
    for (int t = 0; t < n; t++) begin
      int first, slot;
      first = (s_av[t][1] && (!s_av[t][0] || s_aq[t][1] > s_aq[t][0])) ? 1 : 0;
      e_vld[t] = 2'b00; e_lct[t][0] = '0; e_lct[t][1] = '0; slot = 0;
      for (int pass = 0; pass < 2; pass++) begin
        int a;
        bit got;
        a = (pass == 0) ? first : 1 - first;
        got = 0;
        if (s_av[t][a]) begin
          for (int r = 0; r <= 2 * HMAX; r++) begin
            int d, c;
            d = (r + 1) / 2;
            c = (r % 2 == 1) ? t - d : t + d;
            if (!got && d <= h && c >= 0 && c < n && s_cv[c] && !used[c]) begin
              got = 1; used[c] = 1;
              e_lct[t][slot] = {4'(s_aq[t][a] + s_cq[c]), 7'(s_wg[t][a]), 8'(s_hs[c])};
              e_vld[t][slot] = 1'b1;
              slot++;
            end
          end
        end
      end
    end
  endtask

  task automatic drive_zero();
    a_vld = '0; a_wg = '0; a_q = '0; c_vld = 0; c_hs = '0; c_q = '0;
  endtask

  task automatic run_phase(int n, int win, string tag);
    model(n, win);
    @(negedge clk);
    rst = 1; win_sel = 2'(win); drive_zero();
    @(negedge clk); @(negedge clk);
    checks++;
    if (out_vld !== 2'b00) begin
      fails++;
      $display("FAIL R1 reset: out_vld act %b exp 00", out_vld);
    end
    for (int c = 0; c < n + HMAX + 3; c++) begin
      int t;
      t = c - HMAX - 2;
      if (t >= 0 && t < n) begin
        bit ok;
        ok = (out_vld === e_vld[t]);
        if (e_vld[t][0] && out_lct[0] !== e_lct[t][0]) ok = 0;
        if (e_vld[t][1] && out_lct[1] !== e_lct[t][1]) ok = 0;
        if (e_vld[t][0] && out_bx !== 12'(t)) ok = 0;
        checks++;
        if (!ok) begin
          fails++;
          $display("FAIL %s win %0d crossing %0d: vld %b/%b lct0 %h/%h lct1 %h/%h bx %0d/%0d (act/exp)",
                   tag, win, t, out_vld, e_vld[t], out_lct[0], e_lct[t][0],
                   out_lct[1], e_lct[t][1], out_bx, t);
        end
      end
      rst = 0;
      bx_in = 12'(c);
      if (c < n) begin
        a_vld = {s_av[c][1], s_av[c][0]};
        a_wg  = {7'(s_wg[c][1]), 7'(s_wg[c][0])};
        a_q   = {3'(s_aq[c][1]), 3'(s_aq[c][0])};
        c_vld = s_cv[c]; c_hs = 8'(s_hs[c]); c_q = 3'(s_cq[c]);
      end else begin
        drive_zero();
      end
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd24681));
    // R2 R3 R8: exact-crossing match, fields, unmatched anode
    clear_stim();
    put_a(5, 0, 7'h55, 5); put_c(5, 8'hA3, 6);
    put_a(10, 0, 7'h12, 3); put_c(11, 8'h40, 2);
    put_a(15, 1, 7'h7F, 7); put_c(15, 8'hFF, 7);
    run_phase(30, 0, "R2 R3 R8");
    // R4 R5: tie goes to the earlier crossing, edge of window
    clear_stim();
    put_a(5, 0, 7'h01, 1); put_c(4, 8'h04, 1); put_c(6, 8'h06, 2);
    put_a(12, 0, 7'h02, 2); put_c(14, 8'h0E, 3);
    put_a(20, 0, 7'h03, 3); put_c(21, 8'h15, 4);
    run_phase(30, 1, "R4 R5");
    // R5: nearer beats farther in the wide window
    clear_stim();
    put_a(5, 0, 7'h11, 2); put_c(3, 8'h03, 1); put_c(6, 8'h06, 1);
    put_a(15, 0, 7'h22, 4); put_c(13, 8'h0D, 2); put_c(17, 8'h11, 2);
    run_phase(30, 2, "R5");
    // R4: select 3 saturates to the widest window
    clear_stim();
    put_a(5, 0, 7'h33, 1); put_c(7, 8'h07, 1);
    put_a(15, 0, 7'h34, 1); put_c(12, 8'h0C, 1);
    run_phase(30, 3, "R4");
    // R6 R7: quality order and slot filling
    clear_stim();
    put_a(5, 0, 7'h0A, 2); put_a(5, 1, 7'h0B, 6); put_c(5, 8'h50, 1); put_c(4, 8'h40, 3);
    put_a(12, 0, 7'h0C, 7); put_a(12, 1, 7'h0D, 1); put_c(12, 8'hC0, 0);
    put_a(20, 0, 7'h0E, 4); put_a(20, 1, 7'h0F, 4); put_c(20, 8'h20, 2);
    run_phase(30, 1, "R6 R7");
    // R9: cathode used once across crossings and within one crossing
    clear_stim();
    put_a(5, 0, 7'h21, 3); put_a(6, 0, 7'h22, 3); put_c(5, 8'h05, 1);
    put_a(12, 0, 7'h23, 2); put_a(12, 1, 7'h24, 5); put_c(12, 8'h0C, 4);
    run_phase(30, 1, "R9");
    // random streams at each width
    for (int w = 0; w < 3; w++) begin
      clear_stim();
      for (int t = 0; t < 500; t++) begin
        if ($urandom_range(99) < 35) put_a(t, 0, $urandom_range(127), $urandom_range(7));
        if ($urandom_range(99) < 15) put_a(t, 1, $urandom_range(127), $urandom_range(7));
        if ($urandom_range(99) < 40) put_c(t, $urandom_range(255), $urandom_range(7));
      end
      run_phase(500, w, "R4 R5 R6 R9 random");
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R2 watchdog: act running exp finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule